// File: doc/BRIEF.md
# Quadrature Position Decoder with Index Capture

This block turns a two-phase incremental encoder signal pair into a position count, CNT_W bits wide. The two phase inputs and the index input each pass through a two-flop synchroniser. A register holds the previous phase levels. Comparing that register with the present levels gives three things: a valid single-step transition, the direction of the step, or an illegal transition in which both phases changed at once. The count wraps within a maximum position that can be changed at run time. Reverse steps from zero reload the count with the maximum minus one.

Each rising edge of the index input pushes the current count into a small capture FIFO and raises a tagged event. An illegal transition raises an event with a different tag. Control inputs give the surrounding logic these functions:
- holding the counter at zero
- gating the count
- setting the maximum position
- popping or clearing the FIFO

Top module: `qdec_top`

## Requirements
- R1: `enc_a`, `enc_b` and `enc_idx` each pass through a two-flop synchroniser. A level driven before clock edge k affects `position`, `direction` and the event outputs right after edge k+2, and not earlier.
- R2: While `cnt_clear` is 1, `position` reads 0 and steps are ignored. Counting resumes once `cnt_clear` is back at 0.
- R3: A valid step is a change of exactly one phase relative to the stored previous levels. The forward sequence of (A,B) is 00, 10, 11, 01, 00, in which A leads. A forward step sets `direction` to 1 and adds one to `position`. A reverse step sets `direction` to 0 and subtracts one. The count moves by at most one per clock.
- R4: While `cnt_en` is 0, `position` holds. The previous-level register still tracks the phases, so re-enabling the count causes no spurious step. `direction` follows every valid step.
- R5: When an increment would produce a value equal to `max_pos`, the count becomes 0 instead.
- R6: When a decrement from 0 would give all ones, the count is reloaded with `max_pos` - 1.
- R7: A transition in which both phases change leaves the count unchanged. It produces a one-cycle `evt_valid` pulse with `evt_tag` = 11 (decimal) on the rising edge of the internal error flag.
- R8: A rising edge of the index writes the current count into the capture FIFO and produces a one-cycle `evt_valid` pulse with `evt_tag` = 5. A falling edge of the index produces no event.
- R9: If an error event and an index capture arise in the same cycle, tag 11 is presented first and tag 5 follows on the next cycle.
- R10: The FIFO holds FIFO_DEPTH entries, 4 by default. It is read first-in first-out: `fifo_data` shows the oldest entry, `fifo_rd` pops it, and `fifo_empty` is 1 when the FIFO holds nothing.
- R11: A capture into a full FIFO is dropped and sets the sticky `fifo_ovf` flag. `fifo_clr` empties the FIFO and clears `fifo_ovf`.
- R12: A change of `max_pos` applies from the next step. A count already above the new maximum is not clipped: it keeps incrementing and wraps only under R5 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_idx | input | 1 | Encoder index (asynchronous) |
| cnt_clear | input | 1 | Holds the position at zero while 1 |
| cnt_en | input | 1 | Count gate |
| max_pos | input | CNT_W | Maximum position |
| fifo_rd | input | 1 | Pops the oldest capture |
| fifo_clr | input | 1 | Empties the FIFO and clears the overflow flag |
| position | output | CNT_W | Current count |
| direction | output | 1 | Direction of the last valid step, 1 = forward |
| fifo_data | output | CNT_W | Oldest capture |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_ovf | output | 1 | Sticky capture-dropped flag |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_tag | output | 4 | Event code: 11 = error, 5 = capture |

## Verification
The bench builds the block with its default CNT_W of 32 and FIFO_DEPTH of 4. Only `max_pos` is driven to small values (6, then 3), so both wrap rules are reached within a few steps. A depth of four is filled by five index pulses, which reaches the overflow drop and the order of read-back. The 32-bit width also makes the all-ones reload on reverse wrap a real boundary rather than a narrow-counter artefact.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int TAG_W = 4;
  localparam logic [TAG_W-1:0] TAG_ERR = 4'd11;
  localparam logic [TAG_W-1:0] TAG_CAP = 4'd5;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  assign dout = s2_q;
endmodule

// File: rtl/qdec_phase.sv
module qdec_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  logic idx,
  output logic step,
  output logic fwd,
  output logic dir_q,
  output logic err_rise,
  output logic idx_rise
);
  logic pa_q, pb_q, pi_q, err_q, dir_d;
  logic chg_a, chg_b, dbl;

  assign chg_a    = a ^ pa_q;
  assign chg_b    = b ^ pb_q;
  assign step     = chg_a ^ chg_b;
  assign dbl      = chg_a & chg_b;
  assign fwd      = a ^ pb_q;
  assign err_rise = dbl & ~err_q;
  assign idx_rise = idx & ~pi_q;

  always_comb begin
    dir_d = dir_q;
    if (step) dir_d = fwd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= 1'b0;
      pb_q  <= 1'b0;
      pi_q  <= 1'b0;
      err_q <= 1'b0;
      dir_q <= 1'b0;
    end else begin
      pa_q  <= a;
      pb_q  <= b;
      pi_q  <= idx;
      err_q <= dbl;
      dir_q <= dir_d;
    end
  end

  // R7
  err_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_rise |=> !err_rise);
endmodule

// File: rtl/qdec_poscnt.sv
module qdec_poscnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             step,
  input  logic             fwd,
  input  logic [CNT_W-1:0] max_pos,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (en && step) begin
      if (fwd) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_d == max_pos) cnt_d = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
        if (&cnt_d) cnt_d = max_pos - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0);
  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clear) |=> $stable(cnt_q));
  // R3
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) ||
               (cnt_q == $past(cnt_q) - 1'b1) || (cnt_q == '0) ||
               (cnt_q == $past(max_pos) - 1'b1));
endmodule

// File: rtl/qdec_capfifo.sv
module qdec_capfifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  input  logic         clr,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_d, full, do_wr, do_rd;

  assign full  = (cnt_q == FULL);
  assign empty = (cnt_q == '0);
  assign do_wr = wr & ~full & ~clr;
  assign do_rd = rd & ~empty & ~clr;
  assign rdata = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovf_d = ovf;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (do_wr) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (do_wr && !do_rd) cnt_d = cnt_q + 1'b1;
      if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
      if (wr && full) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf   <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end

  // R11
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !clr) |=> ovf && full);
  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic             cnt_clear,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] max_pos,
  input  logic             fifo_rd,
  input  logic             fifo_clr,
  output logic [CNT_W-1:0] position,
  output logic             direction,
  output logic [CNT_W-1:0] fifo_data,
  output logic             fifo_empty,
  output logic             fifo_ovf,
  output logic             evt_valid,
  output logic [TAG_W-1:0] evt_tag
);
  logic       rst_s1_q, rst_sn_q;
  logic [2:0] raw_in, syn_in;
  logic       step, fwd, err_rise, idx_rise;
  logic       pend_q, pend_d, cap_req, evt_v_d;
  logic [TAG_W-1:0] tag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_sn_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_sn_q <= rst_s1_q;
    end
  end

  assign raw_in = {enc_idx, enc_b, enc_a};

  qdec_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_sn_q), .din(raw_in), .dout(syn_in)
  );

  qdec_phase u_phase (
    .clk(clk), .rst_n(rst_sn_q), .a(syn_in[0]), .b(syn_in[1]), .idx(syn_in[2]),
    .step(step), .fwd(fwd), .dir_q(direction), .err_rise(err_rise),
    .idx_rise(idx_rise)
  );

  qdec_poscnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sn_q), .clear(cnt_clear), .en(cnt_en), .step(step),
    .fwd(fwd), .max_pos(max_pos), .cnt_q(position)
  );

  qdec_capfifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sn_q), .wr(idx_rise), .wdata(position), .rd(fifo_rd),
    .clr(fifo_clr), .rdata(fifo_data), .empty(fifo_empty), .ovf(fifo_ovf)
  );

  always_comb begin
    cap_req = idx_rise | pend_q;
    evt_v_d = 1'b0;
    tag_d   = '0;
    pend_d  = pend_q;
    if (err_rise) begin
      evt_v_d = 1'b1;
      tag_d   = TAG_ERR;
      pend_d  = cap_req;
    end else if (cap_req) begin
      evt_v_d = 1'b1;
      tag_d   = TAG_CAP;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn_q) begin
    if (!rst_sn_q) begin
      evt_valid <= 1'b0;
      evt_tag   <= '0;
      pend_q    <= 1'b0;
    end else begin
      evt_valid <= evt_v_d;
      evt_tag   <= tag_d;
      pend_q    <= pend_d;
    end
  end

  // R7
  tag_legal_chk: assert property (@(posedge clk) disable iff (!rst_sn_q)
    evt_valid |-> (evt_tag == TAG_ERR) || (evt_tag == TAG_CAP));
  // R9
  err_first_chk: assert property (@(posedge clk) disable iff (!rst_sn_q)
    (err_rise && idx_rise) ##1 !err_rise |=> evt_valid && evt_tag == TAG_CAP);
  // R8
  cap_evt_chk: assert property (@(posedge clk) disable iff (!rst_sn_q)
    (idx_rise && !err_rise) |=> evt_valid && evt_tag == TAG_CAP);
endmodule

// File: tb/sim_qdec_top.sv
`timescale 1ns/1ps
module sim_qdec_top;
  logic clk = 1'b0;
  logic rst_n, enc_a, enc_b, enc_idx, cnt_clear, cnt_en, fifo_rd, fifo_clr;
  logic [31:0] max_pos, position, fifo_data;
  logic direction, fifo_empty, fifo_ovf, evt_valid;
  logic [3:0] evt_tag;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  qdec_top u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .cnt_clear(cnt_clear), .cnt_en(cnt_en), .max_pos(max_pos),
    .fifo_rd(fifo_rd), .fifo_clr(fifo_clr), .position(position),
    .direction(direction), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_ovf(fifo_ovf), .evt_valid(evt_valid), .evt_tag(evt_tag)
  );

  // {a, b, en, exp_dir, exp_pos}; max_pos = 6
  localparam logic [35:0] VEC [12] = '{
    {2'b10, 1'b1, 1'b1, 32'd1},  // R3 forward
    {2'b11, 1'b1, 1'b1, 32'd2},
    {2'b01, 1'b1, 1'b1, 32'd3},
    {2'b00, 1'b1, 1'b1, 32'd4},
    {2'b10, 1'b1, 1'b1, 32'd5},
    {2'b11, 1'b1, 1'b1, 32'd0},  // R5 wrap at max
    {2'b10, 1'b1, 1'b0, 32'd5},  // R6 reload max-1
    {2'b00, 1'b1, 1'b0, 32'd4},
    {2'b01, 1'b0, 1'b0, 32'd4},  // R4 hold
    {2'b11, 1'b1, 1'b0, 32'd3},
    {2'b01, 1'b0, 1'b1, 32'd3},  // R4 dir tracks
    {2'b11, 1'b1, 1'b0, 32'd2}   // R4 no spurious step
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_ab(input logic [1:0] ab);
    @(negedge clk);
    {enc_a, enc_b} = ab;
    settle();
  endtask

  task automatic pulse_idx();
    @(negedge clk);
    enc_idx = 1'b1;
    settle();
    enc_idx = 1'b0;
    settle();
  endtask

  task automatic pop();
    @(negedge clk);
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  initial begin
    #1_600_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enc_a = 1'b0; enc_b = 1'b0; enc_idx = 1'b0;
    cnt_clear = 1'b0; cnt_en = 1'b1; fifo_rd = 1'b0; fifo_clr = 1'b0;
    max_pos = 32'd6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("reset position", position, 32'd0);
    chk("reset empty R10", {31'd0, fifo_empty}, 32'd1);
    chk("reset evt", {31'd0, evt_valid}, 32'd0);

    foreach (VEC[i]) begin
      @(negedge clk);
      cnt_en = VEC[i][33];
      {enc_a, enc_b} = VEC[i][35:34];
      settle();
      chk("R3/R4/R5/R6 table pos", position, VEC[i][31:0]);
      chk("R3/R4 table dir", {31'd0, direction}, {31'd0, VEC[i][32]});
    end
    cnt_en = 1'b1;

    // R2: clear holds zero, step ignored
    @(negedge clk); cnt_clear = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 clear", position, 32'd0);
    drive_ab(2'b10);
    chk("R2 step during clear", position, 32'd0);
    @(negedge clk); cnt_clear = 1'b0;
    drive_ab(2'b00);
    chk("R2 resume reverse", position, 32'd5);

    // R12: count above new max keeps counting
    @(negedge clk); max_pos = 32'd3;
    drive_ab(2'b10);
    chk("R12 above max", position, 32'd6);

    // R1: latency of three edges
    @(negedge clk); {enc_a, enc_b} = 2'b11;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 not yet", position, 32'd6);
    @(posedge clk); @(negedge clk);
    chk("R1 third edge", position, 32'd7);

    // R7: double change
    drive_ab(2'b00);
    chk("R7 evt valid", {31'd0, evt_valid}, 32'd1);
    chk("R7 evt tag", {28'd0, evt_tag}, 32'd11);
    chk("R7 pos unchanged", position, 32'd7);
    @(negedge clk);
    chk("R7 one cycle", {31'd0, evt_valid}, 32'd0);

    // R8: index capture
    @(negedge clk); enc_idx = 1'b1;
    settle();
    chk("R8 evt valid", {31'd0, evt_valid}, 32'd1);
    chk("R8 evt tag", {28'd0, evt_tag}, 32'd5);
    chk("R8 not empty", {31'd0, fifo_empty}, 32'd0);
    chk("R8 data", fifo_data, 32'd7);
    enc_idx = 1'b0;
    settle();
    chk("R8 falling no evt", {31'd0, evt_valid}, 32'd0);

    // R9: error and capture together
    @(negedge clk); {enc_a, enc_b} = 2'b11; enc_idx = 1'b1;
    settle();
    chk("R9 first tag", {27'd0, evt_valid, evt_tag}, {27'd0, 1'b1, 4'd11});
    @(negedge clk);
    chk("R9 second tag", {27'd0, evt_valid, evt_tag}, {27'd0, 1'b1, 4'd5});
    enc_idx = 1'b0;
    settle();

    // R10/R11: fill, overflow, read order
    drive_ab(2'b01);   // 11->01 forward: 7 -> 8
    pulse_idx();
    drive_ab(2'b00);   // 8 -> 9
    pulse_idx();
    chk("R11 no ovf at full", {31'd0, fifo_ovf}, 32'd0);
    drive_ab(2'b10);   // 9 -> 10
    pulse_idx();
    chk("R11 ovf set", {31'd0, fifo_ovf}, 32'd1);
    chk("R10 head", fifo_data, 32'd7);
    pop();
    chk("R10 second", fifo_data, 32'd7);
    pop();
    chk("R10 third", fifo_data, 32'd8);
    pop();
    chk("R11 fourth not dropped", fifo_data, 32'd9);
    pop();
    chk("R10 empty", {31'd0, fifo_empty}, 32'd1);
    chk("R11 sticky", {31'd0, fifo_ovf}, 32'd1);
    pulse_idx();
    @(negedge clk); fifo_clr = 1'b1;
    @(negedge clk); fifo_clr = 1'b0;
    chk("R11 clr empty", {31'd0, fifo_empty}, 32'd1);
    chk("R11 clr ovf", {31'd0, fifo_ovf}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule